// File: doc/BRIEF.md
# Nibble-Wide Serial Register Slave

This block is the target side of a register access port that moves four bits per serial clock. A master pulls the active-low select low, then clocks a 16-bit header over four data lines: a direction flag followed by a 15-bit register address. After the header come one or more bytes, each split into two nibbles. On a write they go into a small on-chip register file. On a read the block drives them back to the master. Raising select ends the transfer at any point.

All sequencing runs on the falling edge of the serial clock. On that edge the block samples header and write data and launches read data, so the master can drive on rising edges and sample on rising edges. A raised select clears the transfer state and releases the data drivers at once. A separate reset input clears the register contents.

The state machine has eight named states:
- `ST_H0`, `ST_H1`, `ST_H2` and `ST_H3` take the four header nibbles.
- `ST_WHI` and `ST_WLO` take the high and low nibbles of a write byte.
- `ST_RHI` and `ST_RLO` present the high and low nibbles of a read byte.

The transitions are:
- H0 → H1 → H2 → H3 in order.
- H3 → RHI when the direction flag is 1. H3 → WHI when it is 0.
- WHI → WLO, then WLO → WHI, committing the byte and stepping the address.
- RHI → RLO, then RLO → RHI, stepping the address.
- Any state → H0 asynchronously while select is high.

Top module: `nsr_slave`

## Requirements
- R1: While `sel_n` is high the state machine is held in `ST_H0` and `sd_oe` is 0. `sd_oe` drops as soon as `sel_n` rises, without waiting for a clock edge. A read that is cut short does not disturb the next transfer's header.
- R2: Header nibble field positions:
  - Nibble 1: `sd_in[3]` is the direction flag (1 = read, 0 = write), and `sd_in[2:0]` are address bits 14..12.
  - Nibbles 2, 3 and 4: address bits 11..8, 7..4 and 3..0, with `sd_in[3]` the most significant bit of each.
  - The data phase begins right after the fourth header nibble.
- R3: A write byte is received as two nibbles, bits 7..4 first, then bits 3..0. It is stored at the falling edge that samples its second nibble.
- R4: Read data timing and field positions:
  - In a read, `sd_oe` is 1 from the falling edge that samples the fourth header nibble until select rises.
  - `sd_out` first shows bits 7..4 of the addressed register, then bits 3..0.
  - Each nibble changes on a falling edge and is held through the next rising edge.
- R5: After each complete byte, read or written, the address rises by one. The address wraps from 0x7FFF to 0x0000.
- R6: A write byte whose second nibble has not been sampled when select rises is discarded.
- R7: The register file holds `DEPTH` bytes, 16 by default, at addresses 0 to `DEPTH`-1. A write to any other address leaves every register unchanged, and a read from any other address returns 0x00.
- R8: `rst_n` low clears all registers to 0x00.
- R9: `sd_oe` stays 0 during every header and throughout a write transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scl | input | 1 | Serial clock; the block acts on its falling edge |
| sel_n | input | 1 | Active-low transfer select; high ends the transfer |
| rst_n | input | 1 | Active-low asynchronous clear of the register file |
| sd_in | input | 4 | Data lines as received from the pads |
| sd_out | output | 4 | Read nibble to drive onto the data lines |
| sd_oe | output | 1 | Driver enable for the data lines |

## Verification
The assertions check three things on every falling edge:
- After the fourth header nibble the machine always moves into a data state.
- Every completed byte advances the address by exactly one.
- The drivers are enabled only for a read-flagged transfer while select is low.

They also confirm that each in-range write strobe leaves its byte in the addressed register. Only the bench's scenarios can show the rest:
- the nibble-to-address mapping in the header;
- the value read back after bursts;
- address wrap;
- discard of a half-received byte;
- clean recovery after an aborted read;
- the effect of the register-file clear.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
    localparam int unsigned ADDR_W = 15;
    localparam int unsigned NIB_W  = 4;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_H0,
        ST_H1,
        ST_H2,
        ST_H3,
        ST_WHI,
        ST_WLO,
        ST_RHI,
        ST_RLO
    } nsr_state_e;
endpackage

// File: rtl/nsr_seq.sv
module nsr_seq
    import nsr_pkg::*;
(
    input  logic              scl,
    input  logic              sel_n,
    input  logic [NIB_W-1:0]  sd_in,
    output logic [ADDR_W-1:0] addr,
    output logic [NIB_W-1:0]  wr_hi,
    output logic              wr_en,
    output logic              rd_active,
    output logic              rd_lo_sel
);
    nsr_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [NIB_W-1:0]  hi_q;
    logic              rw_q;

    // State register: cleared asynchronously while select is high.
    always_ff @(negedge scl or posedge sel_n) begin
        if (sel_n) begin
            state_q <= ST_H0;
        end else begin
            state_q <= state_d;
        end
    end

    // Header assembly, held write nibble and address stepping.
    always_ff @(negedge scl or posedge sel_n) begin
        if (sel_n) begin
            addr_q <= '0;
            hi_q   <= '0;
            rw_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_H0: begin
                    rw_q   <= sd_in[NIB_W-1];
                    addr_q <= {sd_in[NIB_W-2:0], {(ADDR_W-NIB_W+1){1'b0}}};
                end
                ST_H1:  addr_q[ADDR_W-NIB_W   -: NIB_W] <= sd_in;
                ST_H2:  addr_q[ADDR_W-2*NIB_W -: NIB_W] <= sd_in;
                ST_H3:  addr_q[NIB_W-1:0]               <= sd_in;
                ST_WHI: hi_q <= sd_in;
                ST_WLO, ST_RLO: addr_q <= addr_q + ADDR_W'(1);
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_H0:  state_d = ST_H1;
            ST_H1:  state_d = ST_H2;
            ST_H2:  state_d = ST_H3;
            ST_H3:  state_d = rw_q ? ST_RHI : ST_WHI;
            ST_WHI: state_d = ST_WLO;
            ST_WLO: state_d = ST_WHI;
            ST_RHI: state_d = ST_RLO;
            ST_RLO: state_d = ST_RHI;
            default: state_d = ST_H0;
        endcase
    end

    always_comb begin
        wr_en     = (state_q == ST_WLO) && !sel_n;
        rd_active = ((state_q == ST_RHI) || (state_q == ST_RLO)) && !sel_n;
        rd_lo_sel = (state_q == ST_RLO);
        addr      = addr_q;
        wr_hi     = hi_q;
    end

    // R2
    hdr_len_chk: assert property (@(negedge scl) disable iff (sel_n)
        (state_q == ST_H3) |=> (state_q == ST_WHI || state_q == ST_RHI));

    // R5
    addr_step_chk: assert property (@(negedge scl) disable iff (sel_n)
        (state_q == ST_WLO || state_q == ST_RLO) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

    // R4
    rd_dir_chk: assert property (@(negedge scl) disable iff (sel_n)
        rd_active |-> rw_q);
endmodule

// File: rtl/nsr_regfile.sv
module nsr_regfile
    import nsr_pkg::*;
#(
    parameter int unsigned DEPTH = 16
)(
    input  logic              scl,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx;
    logic              in_range;

    assign idx      = addr[IDX_W-1:0];
    assign in_range = (addr < ADDR_W'(DEPTH));

    always_ff @(negedge scl or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en && in_range) begin
            mem[idx] <= wr_data;
        end
    end

    assign rd_data = in_range ? mem[idx] : '0;

    // R3
    wr_store_chk: assert property (@(negedge scl) disable iff (!rst_n)
        (wr_en && in_range) |=> (mem[$past(idx)] == $past(wr_data)));
endmodule

// File: rtl/nsr_rdpath.sv
module nsr_rdpath
    import nsr_pkg::*;
(
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              rd_active,
    input  logic              rd_lo_sel,
    output logic [NIB_W-1:0]  sd_out,
    output logic              sd_oe
);
    always_comb begin
        sd_oe  = rd_active;
        sd_out = '0;
        if (rd_active) begin
            sd_out = rd_lo_sel ? rd_data[NIB_W-1:0] : rd_data[BYTE_W-1 -: NIB_W];
        end
    end
endmodule

// File: rtl/nsr_slave.sv
module nsr_slave
    import nsr_pkg::*;
#(
    parameter int unsigned DEPTH = 16
)(
    input  logic              scl,
    input  logic              sel_n,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  sd_in,
    output logic [NIB_W-1:0]  sd_out,
    output logic              sd_oe
);
    logic [ADDR_W-1:0] addr;
    logic [NIB_W-1:0]  wr_hi;
    logic              wr_en;
    logic              rd_active;
    logic              rd_lo_sel;
    logic [BYTE_W-1:0] rd_data;

    nsr_seq u_seq (
        .scl       (scl),
        .sel_n     (sel_n),
        .sd_in     (sd_in),
        .addr      (addr),
        .wr_hi     (wr_hi),
        .wr_en     (wr_en),
        .rd_active (rd_active),
        .rd_lo_sel (rd_lo_sel)
    );

    nsr_regfile #(.DEPTH(DEPTH)) u_regs (
        .scl     (scl),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data ({wr_hi, sd_in}),
        .rd_data (rd_data)
    );

    nsr_rdpath u_rd (
        .rd_data   (rd_data),
        .rd_active (rd_active),
        .rd_lo_sel (rd_lo_sel),
        .sd_out    (sd_out),
        .sd_oe     (sd_oe)
    );

    // R1
    oe_release_chk: assert property (@(negedge scl) disable iff (!rst_n)
        sel_n |-> !sd_oe);
endmodule

// File: tb/nsr_slave_tb.sv
module nsr_slave_tb;
    logic       scl = 1'b0;
    logic       sel_n = 1'b1;
    logic       rst_n = 1'b0;
    logic [3:0] sd_in = 4'h0;
    logic [3:0] sd_out;
    logic       sd_oe;

    int n_vec = 0;
    int n_bad = 0;

    always #10 scl = ~scl;

    nsr_slave u_dut (
        .scl    (scl),
        .sel_n  (sel_n),
        .rst_n  (rst_n),
        .sd_in  (sd_in),
        .sd_out (sd_out),
        .sd_oe  (sd_oe)
    );

    // {read flag, 15-bit address, write data or expected read data}
    localparam logic [23:0] VEC [12] = '{
        {1'b0, 15'h0001, 8'h5A},
        {1'b0, 15'h000F, 8'hC3},
        {1'b0, 15'h0008, 8'h81},
        {1'b1, 15'h0001, 8'h5A},
        {1'b1, 15'h000F, 8'hC3},
        {1'b1, 15'h0008, 8'h81},
        {1'b0, 15'h0001, 8'hFF},
        {1'b1, 15'h0001, 8'hFF},
        {1'b0, 15'h4004, 8'h66},
        {1'b1, 15'h0004, 8'h00},
        {1'b1, 15'h4004, 8'h00},
        {1'b1, 15'h000F, 8'hC3}
    };

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_nib(input logic [3:0] n);
        @(posedge scl);
        sel_n = 1'b0;
        sd_in = n;
        #5;
        chk(sd_oe == 1'b0, "R9 drivers off in header/write", {7'd0, sd_oe}, 8'h00);
    endtask

    task automatic send_hdr(input bit rd, input logic [14:0] a);
        send_nib({rd, a[14:12]});
        send_nib(a[11:8]);
        send_nib(a[7:4]);
        send_nib(a[3:0]);
    endtask

    task automatic end_txn();
        @(posedge scl);
        sel_n = 1'b1;
        sd_in = 4'h0;
        #5;
        chk(sd_oe == 1'b0, "R1 release on select high", {7'd0, sd_oe}, 8'h00);
        @(posedge scl);
    endtask

    task automatic write_txn(input logic [14:0] a, input int n,
                             input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic [7:0] d;
        send_hdr(1'b0, a);
        for (int k = 0; k < n; k++) begin
            d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
            send_nib(d[7:4]);
            send_nib(d[3:0]);
        end
        end_txn();
    endtask

    task automatic read_txn(input logic [14:0] a, input int n,
                            input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2,
                            input string tag);
        logic [7:0] e;
        send_hdr(1'b1, a);
        for (int k = 0; k < n; k++) begin
            e = (k == 0) ? e0 : (k == 1) ? e1 : e2;
            @(posedge scl);
            #5;
            chk(sd_oe == 1'b1, {tag, " R4 oe in read"}, {7'd0, sd_oe}, 8'h01);
            chk(sd_out == e[7:4], {tag, " R4 high nibble"}, {4'd0, sd_out}, {4'd0, e[7:4]});
            @(posedge scl);
            #5;
            chk(sd_out == e[3:0], {tag, " R4 low nibble"}, {4'd0, sd_out}, {4'd0, e[3:0]});
        end
        end_txn();
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #35;
        chk(sd_oe == 1'b0, "R1 reset state oe", {7'd0, sd_oe}, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(posedge scl);
        read_txn(15'h0003, 1, 8'h00, 8'h00, 8'h00, "R8 cleared at reset");

        // Vector table: R2 header mapping, R3 writes, R4 reads, R7 range
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][23])
                read_txn(VEC[i][22:8], 1, VEC[i][7:0], 8'h00, 8'h00, $sformatf("R2/R7 vec%0d", i));
            else
                write_txn(VEC[i][22:8], 1, VEC[i][7:0], 8'h00, 8'h00);
        end

        // R5: burst write then burst read
        write_txn(15'h0005, 3, 8'h10, 8'h20, 8'h30);
        read_txn(15'h0005, 3, 8'h10, 8'h20, 8'h30, "R5 burst");

        // R5 wrap from 0x7FFF to 0x0000; R7 out-of-range byte reads 0
        write_txn(15'h7FFF, 2, 8'h11, 8'h22, 8'h00);
        read_txn(15'h0000, 1, 8'h22, 8'h00, 8'h00, "R5 wrap write");
        read_txn(15'h7FFF, 2, 8'h00, 8'h22, 8'h00, "R5/R7 wrap read");

        // R6: partial byte discarded
        write_txn(15'h0002, 1, 8'h3C, 8'h00, 8'h00);
        send_hdr(1'b0, 15'h0002);
        send_nib(4'h9);
        end_txn();
        read_txn(15'h0002, 1, 8'h3C, 8'h00, 8'h00, "R6 partial discarded");

        // R1: aborted read, next header starts clean
        send_hdr(1'b1, 15'h0005);
        @(posedge scl);
        end_txn();
        read_txn(15'h0006, 1, 8'h20, 8'h00, 8'h00, "R1 after aborted read");

        // R8: clear mid-run
        @(negedge scl);
        rst_n = 1'b0;
        #3;
        rst_n = 1'b1;
        read_txn(15'h000F, 1, 8'h00, 8'h00, 8'h00, "R8 clear");
        read_txn(15'h0005, 1, 8'h00, 8'h00, 8'h00, "R8 clear");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule